// File: doc/BRIEF.md
# Reciprocal-Estimate Radix-2^k Integer Divider

This block divides an unsigned dividend of up to `M_W` bits by a normalized `N_W`-bit divisor, whose top bit is set. It returns the integer quotient and the remainder. It does not choose one quotient bit per cycle by comparing. Each iteration instead estimates a whole `K`-bit-weight digit. It takes a fixed window of top bits of the working remainder and multiplies that window by a short reciprocal of the divisor that the caller supplies. The estimated digit times the divisor is subtracted at a fixed alignment. The working remainder then shifts left by `K`, so every iteration addresses the same bit positions. The quotient is built by shift-and-add of the digits.

The estimate is never too large, so the working remainder cannot go negative. It can, however, fall short by a small amount. A settling phase after the digit loop therefore subtracts the divisor and increments the quotient while the remainder is still at least the divisor. This phase is bounded to two corrections.

Control is a five-state machine:
- `ST_IDLE` waits for `start`. On `start` it captures the operands and moves to `ST_EST`.
- `ST_EST` registers the digit estimate and always moves to `ST_SUB`.
- `ST_SUB` subtracts the digit times the divisor and accumulates the quotient. It returns to `ST_EST` for another step, or moves to `ST_FIX` after the last step.
- `ST_FIX` stays in `ST_FIX` while a correction applies. When no correction is needed it latches the results and moves to `ST_DONE`.
- `ST_DONE` raises `done` and always returns to `ST_IDLE`.

Top module: `recip_div`

## Requirements
- R1: While reset is applied and immediately after it is released, `done` is 0, and `quotient` and `remainder` are 0.
- R2: The divisor C must satisfy 2^(N_W-1) <= C <= 2^N_W-1, and `recip` must equal floor(2^(2*RW-1) / (Ct+1)), where RW = K+5 and Ct = floor(C / 2^(N_W-RW)) (the top RW bits of C). Under these conditions, when `done` is 1, `quotient` equals floor(D/C) and `remainder` equals D mod C.
- R3: The digit loop runs L = ceil((M_W-N_W)/K) iterations of two cycles each, with a constant K-bit shift between iterations. Count the rising edges after the edge that accepts `start`. `done` is first seen high after edge number 2L+1+c, where c (0 to 2) is the number of corrections. With the default parameters this is edge 9 to 11.
- R4: No estimated digit is larger than the true digit. The subtraction in `ST_SUB` never borrows, and the bits shifted out at the top of the working remainder are always zero.
- R5: The settling phase applies at most two corrections. Each correction subtracts C from the remainder and adds 1 to the quotient.
- R6: `done` is high for exactly one cycle per division.
- R7: `quotient` and `remainder` change only in the cycle in which `done` rises. Between divisions they hold their last values.
- R8: A `start` pulse while the block is in any state other than `ST_IDLE` has no effect on the running division or its result.
- R9: The operands are sampled only in the cycle that accepts `start`. Changing `dividend`, `divisor` or `recip` afterwards does not alter the result.
- R10: The result is exact at the boundaries: D = 0, D < C, D = C, D = 2^M_W-1 with C = 2^(N_W-1) (largest quotient), and C = 2^N_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division when idle |
| dividend | input | M_W | Unsigned dividend D |
| divisor | input | N_W | Normalized divisor C, top bit set |
| recip | input | K+5 | Truncated reciprocal of C, encoded as in R2 |
| quotient | output | M_W-N_W+1 | floor(D/C), held between divisions |
| remainder | output | N_W | D mod C, held between divisions |
| done | output | 1 | One-cycle pulse when results are updated |

## Verification
A wrong internal state always surfaces at the next `done`, at most 2L+3 edges after `start` is accepted. Three kinds of fault are covered:
- An over-estimated digit makes the working remainder wrap. This shows as a wildly wrong quotient and a remainder at or above the divisor.
- A lost or misplaced shift corrupts the low digits of the quotient.
- A settling phase that applies too many or too few corrections shows as an off-by-one quotient, a remainder out of range, or `done` arriving outside its 9-to-11-edge window.

Operand inputs are scrambled right after acceptance, and `start` is pulsed mid-run. If a register were reloaded while busy, the bench would see the result of the wrong operands.

// File: rtl/recip_div_pkg.sv
package recip_div_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EST,
        ST_SUB,
        ST_FIX,
        ST_DONE
    } div_state_e;

    // Number of K-bit digit steps needed to cover the dividend beyond the divisor.
    function automatic int digit_steps(input int m_w, input int n_w, input int k);
        return (m_w - n_w + k - 1) / k;
    endfunction

endpackage

// File: rtl/recip_div_digit.sv
// Digit estimator: top window of the working remainder times the reciprocal.
module recip_div_digit #(
    parameter int TW = 13,
    parameter int RW = 13,
    parameter int DW = 11
) (
    input  logic [TW-1:0] window,
    input  logic [RW-1:0] recip,
    output logic [DW-1:0] digit
);
    localparam int PW = TW + RW;

    logic [PW-1:0] prod;

    assign prod  = PW'(window) * PW'(recip);
    // Scale back by 2^(RW+2): both factors are floored, so the digit can only be low.
    assign digit = DW'(prod >> (RW + 2));

endmodule

// File: rtl/recip_div_reduce.sv
// Subtract digit*divisor at the fixed alignment of the working remainder.
module recip_div_reduce #(
    parameter int N_W = 32,
    parameter int DW  = 11,
    parameter int RMW = 66,
    parameter int SH  = 24
) (
    input  logic [RMW-1:0] w_in,
    input  logic [DW-1:0]  digit,
    input  logic [N_W-1:0] divisor,
    output logic [RMW-1:0] w_out,
    output logic           borrow
);
    localparam int MW = DW + N_W;
    localparam int EW = (((MW + SH) > RMW) ? (MW + SH) : RMW) + 1;

    logic [MW-1:0] mult;
    logic [EW-1:0] sub_w;
    logic [EW-1:0] w_ext;
    logic [EW-1:0] diff;

    assign mult   = MW'(digit) * MW'(divisor);
    assign sub_w  = EW'(mult) << SH;
    assign w_ext  = EW'(w_in);
    assign diff   = w_ext - sub_w;
    assign borrow = sub_w > w_ext;
    assign w_out  = RMW'(diff);

endmodule

// File: rtl/recip_div_settle.sv
// One correction step: compare partial remainder with divisor, subtract if not below.
module recip_div_settle #(
    parameter int N_W = 32,
    parameter int RFW = 34
) (
    input  logic [RFW-1:0] part,
    input  logic [N_W-1:0] divisor,
    output logic [RFW-1:0] part_next,
    output logic           ge
);
    logic [RFW-1:0] d_ext;

    assign d_ext     = RFW'(divisor);
    assign ge        = part >= d_ext;
    assign part_next = part - d_ext;

endmodule

// File: rtl/recip_div.sv
module recip_div
    import recip_div_pkg::*;
#(
    parameter int M_W = 64,
    parameter int N_W = 32,
    parameter int K   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [M_W-1:0]     dividend,
    input  logic [N_W-1:0]     divisor,
    input  logic [K+4:0]       recip,
    output logic [M_W-N_W:0]   quotient,
    output logic [N_W-1:0]     remainder,
    output logic               done
);
    // Derived sizes
    localparam int L   = digit_steps(M_W, N_W, K);
    localparam int H   = 2;                 // headroom bits of the working remainder
    localparam int RW  = K + 5;             // reciprocal width
    localparam int TW  = K + 5;             // remainder window width
    localparam int DW  = TW - 2;            // digit width
    localparam int RMW = N_W + K * L + H;   // working remainder width
    localparam int SH  = K * (L - 1);       // fixed subtract alignment
    localparam int QOW = M_W - N_W + 1;
    localparam int RFW = N_W + H;           // settling remainder width
    localparam int STW = (L > 1) ? $clog2(L) : 1;
    localparam logic [STW-1:0] LAST_STEP = STW'(L - 1);

    div_state_e     state_q, state_d;
    logic [RMW-1:0] w_q;
    logic [QOW-1:0] acc_q;
    logic [N_W-1:0] c_q;
    logic [RW-1:0]  r_q;
    logic [DW-1:0]  dig_q;
    logic [STW-1:0] step_q;
    logic [RFW-1:0] rf_q;
    logic [1:0]     fix_q;
    logic [QOW-1:0] quo_q;
    logic [N_W-1:0] rem_q;

    logic [TW-1:0]  window;
    logic [DW-1:0]  est_dig;
    logic [RMW-1:0] red_w;
    logic           red_borrow;
    logic [RFW-1:0] rf_next;
    logic           rf_ge;
    logic           last_step;

    assign window    = TW'(w_q >> (RMW - TW));
    assign last_step = (step_q == LAST_STEP);

    recip_div_digit #(.TW(TW), .RW(RW), .DW(DW)) u_digit (
        .window (window),
        .recip  (r_q),
        .digit  (est_dig)
    );

    recip_div_reduce #(.N_W(N_W), .DW(DW), .RMW(RMW), .SH(SH)) u_reduce (
        .w_in    (w_q),
        .digit   (dig_q),
        .divisor (c_q),
        .w_out   (red_w),
        .borrow  (red_borrow)
    );

    recip_div_settle #(.N_W(N_W), .RFW(RFW)) u_settle (
        .part      (rf_q),
        .divisor   (c_q),
        .part_next (rf_next),
        .ge        (rf_ge)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_EST;
            ST_EST:  state_d = ST_SUB;
            ST_SUB:  state_d = last_step ? ST_FIX : ST_EST;
            ST_FIX:  state_d = rf_ge ? ST_FIX : ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q    <= '0;
            acc_q  <= '0;
            c_q    <= '0;
            r_q    <= '0;
            dig_q  <= '0;
            step_q <= '0;
            rf_q   <= '0;
            fix_q  <= '0;
            quo_q  <= '0;
            rem_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        w_q    <= RMW'(dividend);
                        acc_q  <= '0;
                        c_q    <= divisor;
                        r_q    <= recip;
                        step_q <= '0;
                    end
                end
                ST_EST: begin
                    dig_q <= est_dig;
                end
                ST_SUB: begin
                    acc_q <= (acc_q << K) + QOW'(dig_q);
                    if (last_step) begin
                        rf_q  <= RFW'(red_w >> SH);
                        fix_q <= '0;
                    end else begin
                        w_q    <= red_w << K;
                        step_q <= step_q + 1'b1;
                    end
                end
                ST_FIX: begin
                    if (rf_ge) begin
                        rf_q  <= rf_next;
                        acc_q <= acc_q + 1'b1;
                        fix_q <= fix_q + 1'b1;
                    end else begin
                        quo_q <= acc_q;
                        rem_q <= N_W'(rf_q);
                    end
                end
                ST_DONE: begin
                end
                default: begin
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        done      = (state_q == ST_DONE);
        quotient  = quo_q;
        remainder = rem_q;
    end

    // R4
    no_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SUB) |-> !red_borrow);

    // R4
    shift_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SUB && !last_step) |-> ((red_w >> (RMW - K)) == '0));

    // R5
    fix_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIX) |-> (fix_q <= 2'd2));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> (done || ($stable(quotient) && $stable(remainder))));

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(c_q) && $stable(r_q)));

    // R2
    rem_lt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (remainder < c_q));

endmodule

// File: tb/recip_div_test.sv
module recip_div_test;

    localparam int M_W = 64;
    localparam int N_W = 32;
    localparam int K   = 8;
    localparam int RW  = K + 5;
    localparam int L   = (M_W - N_W + K - 1) / K;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [M_W-1:0]    dividend = '0;
    logic [N_W-1:0]    divisor = '0;
    logic [RW-1:0]     recip = '0;
    logic [M_W-N_W:0]  quotient;
    logic [N_W-1:0]    remainder;
    logic              done;

    int unsigned checks = 0;
    int unsigned errors = 0;
    bit          finished = 1'b0;

    recip_div #(.M_W(M_W), .N_W(N_W), .K(K)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .dividend  (dividend),
        .divisor   (divisor),
        .recip     (recip),
        .quotient  (quotient),
        .remainder (remainder),
        .done      (done)
    );

    always #5 clk = ~clk;

    // R2 reciprocal encoding
    function automatic logic [RW-1:0] make_recip(input logic [N_W-1:0] c);
        logic [63:0] ct;
        ct = 64'(c >> (N_W - RW));
        return RW'((64'd1 << (2 * RW - 1)) / (ct + 64'd1));
    endfunction

    task automatic chk_eq(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic chk_range(input string what, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d..%0d", what, act, lo, hi);
        end
    endtask

    task automatic run_case(input logic [63:0] d, input logic [N_W-1:0] c,
                            input bit poke, input string tag);
        logic [63:0]      eq;
        logic [63:0]      er;
        int               edges;
        logic [M_W-N_W:0] q_seen;
        logic [N_W-1:0]   r_seen;
        eq = d / 64'(c);
        er = d % 64'(c);
        @(negedge clk);
        dividend = d;
        divisor  = c;
        recip    = make_recip(c);
        start    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start    = 1'b0;
        // R9: scramble operands after acceptance
        dividend = {$urandom, $urandom};
        divisor  = $urandom;
        recip    = RW'($urandom);
        edges = 0;
        while (done !== 1'b1 && edges < 40) begin
            @(posedge clk);
            edges++;
            @(negedge clk);
            start = (poke && edges == 3);   // R8 busy start
        end
        start = 1'b0;
        chk_range({tag, " R3 R5 latency"}, edges, 2 * L + 1, 2 * L + 3);
        chk_eq({tag, " R2 R9 quotient"}, 64'(quotient), eq);
        chk_eq({tag, " R2 R4 remainder"}, 64'(remainder), er);
        q_seen = quotient;
        r_seen = remainder;
        @(posedge clk);
        @(negedge clk);
        chk_eq({tag, " R6 done falls"}, 64'(done), 64'd0);
        repeat (3) @(negedge clk);
        chk_eq({tag, " R7 quotient held"}, 64'(quotient), 64'(q_seen));
        chk_eq({tag, " R7 remainder held"}, 64'(remainder), 64'(r_seen));
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        // R1 during reset
        chk_eq("R1 done in reset", 64'(done), 64'd0);
        rst_n = 1'b1;
        chk_eq("R1 done after reset", 64'(done), 64'd0);
        chk_eq("R1 quotient after reset", 64'(quotient), 64'd0);
        chk_eq("R1 remainder after reset", 64'(remainder), 64'd0);

        // R10 directed boundaries
        run_case(64'd0, 32'h8000_0000, 1'b0, "R10 zero");
        run_case(64'hFFFF_FFFF_FFFF_FFFF, 32'h8000_0000, 1'b0, "R10 max quotient");
        run_case(64'hFFFF_FFFF_FFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R10 max divisor");
        run_case(64'hFFFF_FFFF_FFFF_FFFF, 32'h8000_0001, 1'b1, "R10 near min divisor");
        run_case(64'h0000_0000_FFFF_FFFE, 32'hFFFF_FFFF, 1'b0, "R10 below divisor");
        run_case(64'h0000_0000_FFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R10 equal");
        run_case(64'h0000_0001_FFFF_FFFD, 32'hFFFF_FFFF, 1'b0, "R10 twice minus one");
        run_case(64'hFFFF_FFFE_0000_0001, 32'hFFFF_FFFF, 1'b1, "R10 exact square");

        // Constrained random
        for (int i = 0; i < 48; i++) begin
            logic [N_W-1:0] c;
            logic [63:0]    d;
            c = {1'b1, 31'($urandom)};
            unique case (i % 4)
                0: d = {$urandom, $urandom};
                1: d = {16'd0, 16'($urandom), $urandom};
                2: d = 64'($urandom) % 64'(c);
                default: d = 64'(c) * 64'($urandom & 32'h7FFF_FFFF) + 64'(c - 1);
            endcase
            run_case(d, c, (i % 5) == 0, "random");
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule